// File: doc/BRIEF.md
# Escalating Recovery Watchdog Controller

This controller supervises a host processor using challenge and response. At the start of every supervision window it sends the host a one-cycle challenge pulse. The host must return an acknowledge before the window closes. A window that closes with no acknowledge is treated as a hang, and the controller then works through a fixed ladder of recovery actions. First it pulses one of several interrupt lines. Next it pulses a software-reboot request, then a hardware-reset pulse, and finally it drives a power-cut output for a programmed hold time. Before moving up a rung, each rung waits one full window for an acknowledge.

After the power-cut rung the host gets a grace interval with no challenge. Monitoring then resumes at the first rung. Sticky status flags record that a hang happened and which rung brought the host back. A fault-code register keeps the last rung reached. Software reads these after it has recovered.

Window length, power hold and grace interval are counted in ticks of a selectable time base: the raw clock, milliseconds, seconds or minutes. Pulse width is counted in clock cycles. An external enable input turns supervision on and off, and a synchronous external clear input returns the whole controller to its reset state.

Top module: `esc_watchdog`

## Requirements
- R1: While enabled with an acknowledging host, `host_chal` is a one-cycle pulse repeating every TMO ticks. TMO values below 2 act as 2. The first challenge follows one cycle after `ext_en` rises.
- R2: A host that acknowledges (`host_ack` high for at least one cycle) inside every window never sees `host_irq`, `reboot_req`, `hw_reset` or `pwr_cut` asserted.
- R3: With no acknowledge, recovery climbs in this order: interrupt, reboot request, hardware reset, power cut. Each later rung starts exactly one window (TMO ticks) after the previous one. The interrupt pulse starts TMO+1 cycles after the unanswered challenge, and `pwr_cut` rises one cycle earlier in its window than a pulse would.
- R4: The interrupt rung asserts only `host_irq[k]`, where k is CFG bits [4:2]. At most one interrupt line is ever high.
- R5: Interrupt, reboot and reset pulses last exactly PW clock cycles, where PW is the PW register bits [7:0]. A value of 0 acts as 1.
- R6: `pwr_cut` stays high for HOLD ticks. GRACE ticks later a new challenge is issued, with no challenge while power is cut. HOLD or GRACE of 0 acts as 1. If the window that follows goes unanswered, the ladder restarts at the interrupt rung.
- R7: An acknowledge inside the window of rung k (1 to 4) sets FLAGS bit k, returns the current stage (STAGE register) to 0 and stops further escalation.
- R8: FLAGS bit 0 is set by every unanswered window. FLAGS bits only clear when written with a one (write-one-to-clear). CODE holds the last rung reached (1 to 4) until an external clear.
- R9: While `ext_en` is low, every output is low from the next cycle, no challenge is issued and the stage reads 0.
- R10: `ext_clr`, like reset, returns every register to its reset value and clears FLAGS and CODE. The reset values are CFG 0, TMO 1000, PW 16, HOLD 100 and GRACE 50.
- R11: CFG bits [1:0] select the tick: 0 is each clock, 1 is every CLK_PER_MS clocks, 2 is 1000 ms ticks and 3 is 60 s ticks.
- R12: Register map at `reg_addr`: 0 CFG, 1 TMO, 2 PW, 3 HOLD, 4 GRACE, 5 FLAGS, 6 CODE, 7 STAGE. Unused bits read zero, and writes to CODE and STAGE are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clr | input | 1 | Synchronous controller clear |
| ext_en | input | 1 | Supervision enable |
| host_ack | input | 1 | Host acknowledge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from address) |
| host_chal | output | 1 | Challenge pulse to host |
| host_irq | output | NUM_IRQ | Interrupt lines, one selected for the first rung |
| reboot_req | output | 1 | Software-reboot request pulse |
| hw_reset | output | 1 | Hardware-reset pulse |
| pwr_cut | output | 1 | Power-switch drive, high while power is cut |

## Verification
A wrong stage or window counter shows up at the ports within one window. It appears as a recovery pulse arriving one window early or late, on the wrong line, or in the wrong order. Exact cycle counts between challenge, interrupt, reboot, reset and power-cut edges expose an off-by-one in the counters or the pulse stretchers immediately. Flag corruption is only visible when software reads FLAGS or CODE, so the bench reads them right after each recovery and after each clearing write. A stuck enable or clear path appears as outputs or challenges persisting two cycles after the input drops.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CNT_W  = 16;
    localparam int PW_W   = 8;
    localparam int STG_W  = 3;
    localparam int N_ACT  = 3;
    localparam int N_FLAG = 5;
    localparam int AW     = 3;

    localparam logic [STG_W-1:0] STG_PWR = 3'd4;

    localparam logic [AW-1:0] A_CFG   = 3'd0;
    localparam logic [AW-1:0] A_TMO   = 3'd1;
    localparam logic [AW-1:0] A_PW    = 3'd2;
    localparam logic [AW-1:0] A_HOLD  = 3'd3;
    localparam logic [AW-1:0] A_GRACE = 3'd4;
    localparam logic [AW-1:0] A_FLAGS = 3'd5;
    localparam logic [AW-1:0] A_CODE  = 3'd6;
    localparam logic [AW-1:0] A_STAGE = 3'd7;

    typedef enum logic [1:0] {PH_IDLE, PH_WIN, PH_OFF, PH_GRACE} phase_e;
    typedef enum logic [1:0] {TB_CLK, TB_MS, TB_SEC, TB_MIN} tbase_e;

    typedef struct packed {
        phase_e             phase;
        logic [STG_W-1:0]   stage;
        logic [STG_W-1:0]   code;
        logic [CNT_W-1:0]   cnt;
        logic               ack_seen;
        logic               chal;
        logic [N_ACT-1:0]   fire;
        logic [N_FLAG-1:0]  flag_set;
    } core_st_t;

    // last count index of an interval, with a lower bound on the interval
    function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] v,
                                                   input logic [CNT_W-1:0] lo);
        return ((v < lo) ? lo : v) - 1'b1;
    endfunction
endpackage

// File: rtl/wdg_timebase.sv
module wdg_timebase
    import wdg_pkg::*;
#(
    parameter int CLK_PER_MS = 50000,
    parameter int MS_PER_S   = 1000,
    parameter int S_PER_MIN  = 60
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  tbase_e sel,
    output logic   tick
);
    localparam int N_DIV = 3;
    localparam int CW    = 32;

    function automatic int div_of(input int i);
        case (i)
            0:       return CLK_PER_MS;
            1:       return MS_PER_S;
            default: return S_PER_MIN;
        endcase
    endfunction

    logic [N_DIV:0] stg_tick;
    assign stg_tick[0] = 1'b1;

    generate
        for (genvar g = 0; g < N_DIV; g++) begin : g_div
            localparam logic [CW-1:0] LAST = CW'(div_of(g) - 1);
            logic [CW-1:0] cnt_d, cnt_q;
            logic          wrap;

            always_comb begin
                wrap  = stg_tick[g] && (cnt_q == LAST);
                cnt_d = cnt_q;
                if (clr)
                    cnt_d = '0;
                else if (stg_tick[g])
                    cnt_d = wrap ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign stg_tick[g+1] = wrap;
        end
    endgenerate

    assign tick = stg_tick[2'(sel)];
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse
    import wdg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            fire,
    input  logic [PW_W-1:0] width,
    output logic            pulse
);
    logic [PW_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (fire)
            cnt_d = (width == '0) ? PW_W'(1) : width;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int               SEL_W     = 3,
    parameter logic [CNT_W-1:0] RST_TMO   = 16'd1000,
    parameter logic [PW_W-1:0]  RST_PW    = 8'd16,
    parameter logic [CNT_W-1:0] RST_HOLD  = 16'd100,
    parameter logic [CNT_W-1:0] RST_GRACE = 16'd50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic [N_FLAG-1:0] flag_set,
    input  logic [STG_W-1:0]  code,
    input  logic [STG_W-1:0]  stage,
    output tbase_e            base,
    output logic [SEL_W-1:0]  line,
    output logic [CNT_W-1:0]  tmo,
    output logic [PW_W-1:0]   pw,
    output logic [CNT_W-1:0]  hold,
    output logic [CNT_W-1:0]  grace,
    output logic [N_FLAG-1:0] flags
);
    typedef struct packed {
        tbase_e             base;
        logic [SEL_W-1:0]   line;
        logic [CNT_W-1:0]   tmo;
        logic [PW_W-1:0]    pw;
        logic [CNT_W-1:0]   hold;
        logic [CNT_W-1:0]   grace;
        logic [N_FLAG-1:0]  flags;
    } reg_st_t;

    localparam reg_st_t REG_RST = '{
        base:  TB_CLK,
        line:  '0,
        tmo:   RST_TMO,
        pw:    RST_PW,
        hold:  RST_HOLD,
        grace: RST_GRACE,
        flags: '0
    };

    reg_st_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d = REG_RST;
        end else begin
            if (we) begin
                case (addr)
                    A_CFG: begin
                        d.base = tbase_e'(wdata[1:0]);
                        d.line = wdata[2 +: SEL_W];
                    end
                    A_TMO:   d.tmo   = wdata;
                    A_PW:    d.pw    = wdata[PW_W-1:0];
                    A_HOLD:  d.hold  = wdata;
                    A_GRACE: d.grace = wdata;
                    A_FLAGS: d.flags = q.flags & ~wdata[N_FLAG-1:0];
                    default: ;
                endcase
            end
            d.flags = d.flags | flag_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REG_RST;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG: begin
                rdata[1:0]         = q.base;
                rdata[2 +: SEL_W]  = q.line;
            end
            A_TMO:   rdata              = q.tmo;
            A_PW:    rdata[PW_W-1:0]    = q.pw;
            A_HOLD:  rdata              = q.hold;
            A_GRACE: rdata              = q.grace;
            A_FLAGS: rdata[N_FLAG-1:0]  = q.flags;
            A_CODE:  rdata[STG_W-1:0]   = code;
            A_STAGE: rdata[STG_W-1:0]   = stage;
            default: ;
        endcase
    end

    assign base  = q.base;
    assign line  = q.line;
    assign tmo   = q.tmo;
    assign pw    = q.pw;
    assign hold  = q.hold;
    assign grace = q.grace;
    assign flags = q.flags;
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              tick,
    input  logic              ack,
    input  logic [CNT_W-1:0]  tmo,
    input  logic [CNT_W-1:0]  hold,
    input  logic [CNT_W-1:0]  grace,
    output logic              chal,
    output logic [N_ACT-1:0]  fire,
    output logic [N_FLAG-1:0] flag_set,
    output logic [STG_W-1:0]  stage,
    output logic [STG_W-1:0]  code,
    output logic              pwr_off
);
    localparam core_st_t CORE_RST = '{
        phase:    PH_IDLE,
        stage:    '0,
        code:     '0,
        cnt:      '0,
        ack_seen: 1'b0,
        chal:     1'b0,
        fire:     '0,
        flag_set: '0
    };

    core_st_t         d, q;
    logic [STG_W-1:0] nxt;
    logic [CNT_W-1:0] tmo_last, hold_last, grace_last;

    assign tmo_last   = last_idx(tmo,   CNT_W'(2));
    assign hold_last  = last_idx(hold,  CNT_W'(1));
    assign grace_last = last_idx(grace, CNT_W'(1));

    always_comb begin
        d          = q;
        d.chal     = 1'b0;
        d.fire     = '0;
        d.flag_set = '0;
        nxt        = q.stage;
        if (clr) begin
            d = CORE_RST;
        end else if (!en) begin
            d.phase    = PH_IDLE;
            d.stage    = '0;
            d.cnt      = '0;
            d.ack_seen = 1'b0;
        end else begin
            case (q.phase)
                PH_IDLE: begin
                    d.phase    = PH_WIN;
                    d.cnt      = '0;
                    d.ack_seen = 1'b0;
                    d.chal     = 1'b1;
                end
                PH_WIN: begin
                    if (ack) d.ack_seen = 1'b1;
                    if (tick) begin
                        if (q.cnt >= tmo_last) begin
                            d.cnt      = '0;
                            d.ack_seen = 1'b0;
                            if (q.ack_seen || ack) begin
                                if (q.stage != '0) d.flag_set[q.stage] = 1'b1;
                                d.stage = '0;
                                d.chal  = 1'b1;
                            end else begin
                                d.flag_set[0] = 1'b1;
                                nxt     = (q.stage == STG_PWR) ? STG_W'(1) : q.stage + 1'b1;
                                d.stage = nxt;
                                d.code  = nxt;
                                if (nxt == STG_PWR) begin
                                    d.phase = PH_OFF;
                                end else begin
                                    d.fire[2'(nxt - 1'b1)] = 1'b1;
                                    d.chal = 1'b1;
                                end
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_OFF: begin
                    if (tick) begin
                        if (q.cnt >= hold_last) begin
                            d.phase = PH_GRACE;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_GRACE: begin
                    if (tick) begin
                        if (q.cnt >= grace_last) begin
                            d.phase    = PH_WIN;
                            d.cnt      = '0;
                            d.ack_seen = 1'b0;
                            d.chal     = 1'b1;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: d = CORE_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CORE_RST;
        else        q <= d;
    end

    assign chal     = q.chal;
    assign fire     = q.fire;
    assign flag_set = q.flag_set;
    assign stage    = q.stage;
    assign code     = q.code;
    assign pwr_off  = (q.phase == PH_OFF);
endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
    import wdg_pkg::*;
#(
    parameter int               NUM_IRQ    = 8,
    parameter int               CLK_PER_MS = 50000,
    parameter int               MS_PER_S   = 1000,
    parameter int               S_PER_MIN  = 60,
    parameter logic [CNT_W-1:0] RST_TMO    = 16'd1000,
    parameter logic [PW_W-1:0]  RST_PW     = 8'd16,
    parameter logic [CNT_W-1:0] RST_HOLD   = 16'd100,
    parameter logic [CNT_W-1:0] RST_GRACE  = 16'd50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_clr,
    input  logic               ext_en,
    input  logic               host_ack,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    output logic               host_chal,
    output logic [NUM_IRQ-1:0] host_irq,
    output logic               reboot_req,
    output logic               hw_reset,
    output logic               pwr_cut
);
    localparam int SEL_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    tbase_e            base;
    logic [SEL_W-1:0]  irq_line;
    logic [CNT_W-1:0]  tmo, hold, grace;
    logic [PW_W-1:0]   pw;
    logic [N_FLAG-1:0] flags_w, flag_set;
    logic [STG_W-1:0]  stage_w, code_w;
    logic [N_ACT-1:0]  act_fire, act_pulse;
    logic              tick;
    logic              quiet;

    assign quiet = ext_clr || !ext_en;

    wdg_timebase #(
        .CLK_PER_MS (CLK_PER_MS),
        .MS_PER_S   (MS_PER_S),
        .S_PER_MIN  (S_PER_MIN)
    ) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ext_clr),
        .sel   (base),
        .tick  (tick)
    );

    wdg_regs #(
        .SEL_W     (SEL_W),
        .RST_TMO   (RST_TMO),
        .RST_PW    (RST_PW),
        .RST_HOLD  (RST_HOLD),
        .RST_GRACE (RST_GRACE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ext_clr),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .flag_set (flag_set),
        .code     (code_w),
        .stage    (stage_w),
        .base     (base),
        .line     (irq_line),
        .tmo      (tmo),
        .pw       (pw),
        .hold     (hold),
        .grace    (grace),
        .flags    (flags_w)
    );

    wdg_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ext_clr),
        .en       (ext_en),
        .tick     (tick),
        .ack      (host_ack),
        .tmo      (tmo),
        .hold     (hold),
        .grace    (grace),
        .chal     (host_chal),
        .fire     (act_fire),
        .flag_set (flag_set),
        .stage    (stage_w),
        .code     (code_w),
        .pwr_off  (pwr_cut)
    );

    generate
        for (genvar a = 0; a < N_ACT; a++) begin : g_act
            wdg_pulse u_pulse (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (quiet),
                .fire  (act_fire[a]),
                .width (pw),
                .pulse (act_pulse[a])
            );
        end
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
            assign host_irq[i] = act_pulse[0] && (irq_line == SEL_W'(i));
        end
    endgenerate

    assign reboot_req = act_pulse[1];
    assign hw_reset   = act_pulse[2];
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
    import wdg_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ext_en,
    input logic               ext_clr,
    input logic               reg_we,
    input logic [AW-1:0]      reg_addr,
    input logic [N_FLAG-1:0]  wipe_data,
    input logic               host_chal,
    input logic [NUM_IRQ-1:0] host_irq,
    input logic               reboot_req,
    input logic               hw_reset,
    input logic               pwr_cut,
    input logic [STG_W-1:0]   stage,
    input logic [N_FLAG-1:0]  flags
);
    logic              en_q, clr_q;
    logic [N_FLAG-1:0] flags_q, wipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            clr_q   <= 1'b0;
            flags_q <= '0;
            wipe_q  <= '0;
        end else begin
            en_q    <= ext_en;
            clr_q   <= ext_clr;
            flags_q <= flags;
            wipe_q  <= (reg_we && reg_addr == A_FLAGS) ? wipe_data : '0;
        end
    end

    AST_CHAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_chal |=> !host_chal) else $error("challenge longer than one cycle"); // R1

    AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(host_irq)) else $error("more than one interrupt line"); // R4

    AST_PWR_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cut |-> (stage == STG_PWR && !host_chal)) else $error("power cut outside last rung"); // R6

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q || ((flags_q & ~flags & ~wipe_q) == '0)) else $error("flag dropped without clear"); // R8

    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (host_irq == '0 && !reboot_req && !hw_reset && !pwr_cut && !host_chal && stage == '0))
        else $error("activity while disabled"); // R9
endmodule

bind esc_watchdog wdg_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_en     (ext_en),
    .ext_clr    (ext_clr),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .wipe_data  (reg_wdata[4:0]),
    .host_chal  (host_chal),
    .host_irq   (host_irq),
    .reboot_req (reboot_req),
    .hw_reset   (hw_reset),
    .pwr_cut    (pwr_cut),
    .stage      (stage_w),
    .flags      (flags_w)
);

// File: tb/esc_watchdog_test.sv
module esc_watchdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 4;
    localparam int NIRQ       = 8;
    localparam int TMO        = 10;
    localparam int PW         = 3;
    localparam int HOLD       = 6;
    localparam int GRACE      = 4;
    localparam int LINE       = 5;

    localparam int K_CHAL = 0, K_IRQ = 1, K_RBT = 2, K_RST = 3, K_PWR = 4;

    // {addr, write data, expected readback}
    localparam logic [34:0] VEC [8] = '{
        {3'd0, 16'hFF14, 16'h0014},
        {3'd1, 16'd10,   16'd10},
        {3'd2, 16'h1203, 16'h0003},
        {3'd3, 16'd6,    16'd6},
        {3'd4, 16'd4,    16'd4},
        {3'd6, 16'd7,    16'd0},
        {3'd7, 16'd3,    16'd0},
        {3'd5, 16'd31,   16'd0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ext_clr = 1'b0;
    logic            ext_en = 1'b0;
    logic            host_ack = 1'b0;
    logic            reg_we = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_rdata;
    logic            host_chal;
    logic [NIRQ-1:0] host_irq;
    logic            reboot_req, hw_reset, pwr_cut;

    logic auto_ack = 1'b0;
    logic done = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;

    esc_watchdog #(.NUM_IRQ(NIRQ), .CLK_PER_MS(CPM)) uut (
        .clk(clk), .rst_n(rst_n), .ext_clr(ext_clr), .ext_en(ext_en),
        .host_ack(host_ack), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_chal(host_chal),
        .host_irq(host_irq), .reboot_req(reboot_req), .hw_reset(hw_reset),
        .pwr_cut(pwr_cut)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // host model: answers each challenge at once while auto_ack is set
    initial forever begin
        @(negedge clk);
        if (auto_ack) host_ack = host_chal;
    end

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic probe(input int k);
        case (k)
            K_CHAL:  return host_chal;
            K_IRQ:   return |host_irq;
            K_RBT:   return reboot_req;
            K_RST:   return hw_reset;
            default: return pwr_cut;
        endcase
    endfunction

    task automatic until_lvl(input int k, input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (probe(k) !== lvl && n < 5000);
    endtask

    task automatic idle(input int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic pulse_ack();
        @(negedge clk); host_ack = 1'b1;
        @(negedge clk); host_ack = 1'b0;
    endtask

    task automatic count_activity(input int c, output int hits);
        hits = 0;
        for (int i = 0; i < c; i++) begin
            @(negedge clk);
            if ((|host_irq) || reboot_req || hw_reset || pwr_cut) hits++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v, n, hits;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R10: reset state
        check(int'({host_chal, host_irq, reboot_req, hw_reset, pwr_cut}), 0, "R10 outputs after reset");
        rd(3'd1, v); check(v, 1000, "R10 TMO reset");
        rd(3'd2, v); check(v, 16, "R10 PW reset");
        rd(3'd3, v); check(v, 100, "R10 HOLD reset");
        rd(3'd4, v); check(v, 50, "R10 GRACE reset");
        rd(3'd0, v); check(v, 0, "R10 CFG reset");

        // R12: register table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][34:32], VEC[i][31:16]);
            rd(VEC[i][34:32], v);
            check(v, int'(VEC[i][15:0]), $sformatf("R12 reg %0d readback", VEC[i][34:32]));
        end

        // R1: challenge period with an answering host
        auto_ack = 1'b1;
        @(negedge clk); ext_en = 1'b1;
        until_lvl(K_CHAL, 1'b1, n);
        check(n, 1, "R1 first challenge after enable");
        until_lvl(K_CHAL, 1'b1, n);
        check(n, TMO, "R1 challenge period");

        // R2: healthy host sees no recovery
        count_activity(60, hits);
        check(hits, 0, "R2 no recovery with answers");

        // R3/R4/R5/R6: full escalation ladder
        until_lvl(K_CHAL, 1'b1, n);
        idle(3); auto_ack = 1'b0;
        until_lvl(K_CHAL, 1'b1, n);
        until_lvl(K_IRQ, 1'b1, n);
        check(n, TMO + 1, "R3 interrupt delay after challenge");
        check(int'(host_irq), 1 << LINE, "R4 selected interrupt line");
        until_lvl(K_IRQ, 1'b0, n);
        check(n, PW, "R5 interrupt pulse width");
        until_lvl(K_RBT, 1'b1, n);
        check(n, TMO - PW, "R3 reboot one window later");
        until_lvl(K_RBT, 1'b0, n);
        check(n, PW, "R5 reboot pulse width");
        until_lvl(K_RST, 1'b1, n);
        check(n, TMO - PW, "R3 reset one window later");
        until_lvl(K_RST, 1'b0, n);
        check(n, PW, "R5 reset pulse width");
        until_lvl(K_PWR, 1'b1, n);
        check(n, TMO - PW - 1, "R3 power cut one window later");
        until_lvl(K_PWR, 1'b0, n);
        check(n, HOLD, "R6 power hold length");
        until_lvl(K_CHAL, 1'b1, n);
        check(n, GRACE, "R6 grace before challenge");
        rd(3'd6, v); check(v, 4, "R8 code after power rung");
        rd(3'd7, v); check(v, 4, "R6 stage during post-power window");
        rd(3'd5, v); check(v, 1, "R8 hang flag only");

        // R7: recovery at power rung
        pulse_ack();
        idle(2); auto_ack = 1'b1;
        count_activity(30, hits);
        check(hits, 0, "R7 no escalation after power recovery");
        rd(3'd5, v); check(v, 17, "R7 flag for power rung");
        rd(3'd7, v); check(v, 0, "R7 stage back to zero");

        // R8: write-one-to-clear
        wr(3'd5, 16'd1);
        rd(3'd5, v); check(v, 16, "R8 clear hang bit only");
        wr(3'd5, 16'd16);
        rd(3'd5, v); check(v, 0, "R8 clear remaining bit");
        rd(3'd6, v); check(v, 4, "R8 code kept");

        // R7: recovery at interrupt rung
        until_lvl(K_CHAL, 1'b1, n);
        idle(3); auto_ack = 1'b0;
        until_lvl(K_IRQ, 1'b1, n);
        pulse_ack();
        idle(2); auto_ack = 1'b1;
        count_activity(30, hits);
        check(hits, 0, "R7 no reboot after interrupt recovery");
        rd(3'd5, v); check(v, 3, "R7 flag for interrupt rung");
        rd(3'd6, v); check(v, 1, "R8 code is interrupt rung");
        wr(3'd5, 16'd31);

        // R9: disable during power cut
        until_lvl(K_CHAL, 1'b1, n);
        idle(3); auto_ack = 1'b0;
        until_lvl(K_PWR, 1'b1, n);
        ext_en = 1'b0;
        idle(2);
        check(int'({host_chal, host_irq, reboot_req, hw_reset, pwr_cut}), 0, "R9 outputs off when disabled");
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (host_chal || pwr_cut) n++;
        end
        check(n, 0, "R9 no challenge or power cut while disabled");
        rd(3'd7, v); check(v, 0, "R9 stage zero while disabled");
        auto_ack = 1'b1;
        ext_en = 1'b1;
        until_lvl(K_CHAL, 1'b1, n);
        check(n, 1, "R9 challenge after re-enable");

        // R10: external clear
        rd(3'd5, v); check(v, 1, "R8 hang flag before clear");
        @(negedge clk); ext_clr = 1'b1;
        @(negedge clk); ext_clr = 1'b0;
        rd(3'd5, v); check(v, 0, "R10 flags cleared");
        rd(3'd6, v); check(v, 0, "R10 code cleared");
        rd(3'd1, v); check(v, 1000, "R10 TMO restored");
        rd(3'd0, v); check(v, 0, "R10 CFG restored");

        // R11: millisecond time base
        ext_en = 1'b0; auto_ack = 1'b0;
        idle(2);
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd3);
        ext_en = 1'b1;
        until_lvl(K_CHAL, 1'b1, n);
        until_lvl(K_IRQ, 1'b1, n);
        check(int'(n >= 2 * CPM + 2 && n <= 3 * CPM + 1), 1, $sformatf("R11 ms base delay %0d", n));
        check(int'(host_irq), 1, "R4 interrupt line zero");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule